// File: doc/BRIEF.md
# Segment Address Translation and Access Checker

This block sits between address generation and the paging stage. Each request gives it a segment descriptor that has already been unpacked into fields, the privilege of the running code, the privilege requested by the selector, the kind of access and a segment-relative offset. It checks the access against the descriptor. If every check passes, it returns the linear address, which is the 32-bit segment base plus the offset. If a check fails, it returns a fault code and no address.

Requests enter through a valid/ready pair. The result comes back one cycle later from a registered response stage that has its own valid/ready pair. While the consumer stalls, the response stays unchanged. The descriptor limit is 20 bits wide. A granularity flag selects whether that limit counts bytes or 4 KB pages. The 32-bit operand-size flag passes through with each response.

Top module: `seg_addr_chk`

## Requirements
- R1: When no check fails, `fault_o` is 0 (none) and `lin_addr_o` equals `base_i + offset_i` modulo 2^32.
- R2: With `gran_i`=0, the effective limit is `limit_i` in bytes. An offset equal to the limit is allowed. An offset one above it gives fault code 4 (limit).
- R3: With `gran_i`=1, the effective limit is `(limit_i << 12) | 0xFFF`. Offsets up to that value are allowed. Larger offsets give fault code 4.
- R4: With `present_i`=0, the response is fault code 1 (absent). Whenever the fault code is non-zero, `lin_addr_o` is 0.
- R5: With `seg_s_i`=0, the descriptor is a system descriptor, and the response is fault code 2 (system).
- R6: Privilege levels are 0 (most privileged) to 3. When the larger of `cpl_i` and `rpl_i` exceeds `dpl_i`, the response is fault code 3 (protection). Equal values pass.
- R7: `acc_i` encodes read=0, write=1, execute=2. A write gives fault code 3 when `type_i[3]`=1 (code segment) or when `type_i[1]`=0 (data segment not writable).
- R8: An execute access to a data segment (`type_i[3]`=0) gives fault code 3. So does a read of a code segment with `type_i[1]`=0 (not readable). `acc_i`=3 is reserved and always gives fault code 3. `type_i[0]` and `type_i[2]` have no effect on the result.
- R9: When several checks fail, the reported code follows this priority: absent (1), then system (2), then protection (3), then limit (4).
- R10: `op32_o` in each response equals the `dflt32_i` that came with the request.
- R11: Each request accepted (`req_valid_i` and `req_ready_o` both high at a clock edge) produces exactly one response, valid in the next cycle. While `rsp_valid_o`=1 and `rsp_ready_i`=0, the response holds steady and `req_ready_o` is 0.
- R12: During and right after reset, `rsp_valid_o` is 0 and `req_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| base_i | input | 32 | Segment base |
| limit_i | input | 20 | Raw segment limit |
| gran_i | input | 1 | Limit counts 4 KB pages when 1 |
| present_i | input | 1 | Segment present |
| seg_s_i | input | 1 | 1 = code/data descriptor, 0 = system descriptor |
| type_i | input | 4 | Segment type: [3] code, [1] writable (data) or readable (code) |
| dpl_i | input | 2 | Descriptor privilege level |
| dflt32_i | input | 1 | Default operand size is 32 bits |
| cpl_i | input | 2 | Current privilege level |
| rpl_i | input | 2 | Requested privilege level |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| offset_i | input | 32 | Effective offset within the segment |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Consumer takes the response |
| lin_addr_o | output | 32 | Linear address, 0 on a fault |
| fault_o | output | 3 | 0 none, 1 absent, 2 system, 3 protection, 4 limit |
| op32_o | output | 1 | Operand size flag of the answered request |

## Verification
Offsets are placed exactly on the effective limit and one above it, under both byte and page granularity. This separates an off-by-one compare and a wrong page scale from correct behaviour. Privilege is exercised with the current level alone above the descriptor level, the requested level alone above it, and both equal to it. These cases show whether both levels feed the comparison. Each combination of access kind and segment type is applied. Requests that break several rules at once show whether the priority order holds. A stalled consumer shows whether the response stays stable and whether back-pressure reaches the request side.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    FLT_NONE   = 3'd0,
    FLT_ABSENT = 3'd1,
    FLT_SYS    = 3'd2,
    FLT_PROT   = 3'd3,
    FLT_LIMIT  = 3'd4
  } fault_e;

  localparam int unsigned TYPE_CODE_BIT = 3;
  localparam int unsigned TYPE_RW_BIT   = 1;
endpackage

// File: rtl/seg_lim_unit.sv
module seg_lim_unit #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIMIT_W    = 20,
  parameter int unsigned PAGE_SHIFT = 12
) (
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               gran_i,
  input  logic [ADDR_W-1:0]  offset_i,
  output logic               over_o
);
  localparam int unsigned PG_W = LIMIT_W + PAGE_SHIFT;

  logic [ADDR_W-1:0] byte_lim;
  logic [ADDR_W-1:0] page_lim;
  logic [ADDR_W-1:0] eff_lim;

  assign byte_lim = ADDR_W'(limit_i);

  generate
    if (PG_W >= ADDR_W) begin : g_page_full
      // scaled limit fills or exceeds the address space: keep low bits
      logic [PG_W-1:0] pg_wide;
      assign pg_wide  = {limit_i, {PAGE_SHIFT{1'b1}}};
      assign page_lim = pg_wide[ADDR_W-1:0];
    end else begin : g_page_ext
      assign page_lim = ADDR_W'({limit_i, {PAGE_SHIFT{1'b1}}});
    end
  endgenerate

  assign eff_lim = gran_i ? page_lim : byte_lim;
  assign over_o  = offset_i > eff_lim;
endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
  import seg_chk_pkg::*;
#(
  parameter int unsigned PL_W   = 2,
  parameter int unsigned TYPE_W = 4
) (
  input  logic              present_i,
  input  logic              seg_s_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [PL_W-1:0]   dpl_i,
  input  logic [PL_W-1:0]   cpl_i,
  input  logic [PL_W-1:0]   rpl_i,
  input  logic [1:0]        acc_i,
  input  logic              over_i,
  output fault_e            fault_o
);
  logic [PL_W-1:0] eff_pl;
  logic            priv_bad;
  logic            type_bad;
  logic            is_code;
  logic            rw_bit;

  assign eff_pl   = (cpl_i > rpl_i) ? cpl_i : rpl_i;
  assign priv_bad = eff_pl > dpl_i;
  assign is_code  = type_i[TYPE_CODE_BIT];
  assign rw_bit   = type_i[TYPE_RW_BIT];

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_RD:  type_bad = is_code && !rw_bit;
      ACC_WR:  type_bad = is_code || !rw_bit;
      ACC_EX:  type_bad = !is_code;
      default: type_bad = 1'b1;
    endcase
  end

  always_comb begin
    if (!present_i)                fault_o = FLT_ABSENT;
    else if (!seg_s_i)             fault_o = FLT_SYS;
    else if (priv_bad || type_bad) fault_o = FLT_PROT;
    else if (over_i)               fault_o = FLT_LIMIT;
    else                           fault_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_resp_reg.sv
module seg_resp_reg #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned FAULT_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [ADDR_W-1:0]  lin_i,
  input  logic [FAULT_W-1:0] fault_i,
  input  logic               op32_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [ADDR_W-1:0]  lin_o,
  output logic [FAULT_W-1:0] fault_o,
  output logic               op32_o
);
  logic take;

  assign in_ready_o = !out_valid_o || out_ready_i;
  assign take       = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      lin_o       <= '0;
      fault_o     <= '0;
      op32_o      <= 1'b0;
    end else begin
      if (take) begin
        out_valid_o <= 1'b1;
        lin_o       <= lin_i;
        fault_o     <= fault_i;
        op32_o      <= op32_i;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
  import seg_chk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LIMIT_W    = 20,
  parameter int unsigned PAGE_SHIFT = 12,
  parameter int unsigned PL_W       = 2,
  parameter int unsigned TYPE_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               gran_i,
  input  logic               present_i,
  input  logic               seg_s_i,
  input  logic [TYPE_W-1:0]  type_i,
  input  logic [PL_W-1:0]    dpl_i,
  input  logic               dflt32_i,
  input  logic [PL_W-1:0]    cpl_i,
  input  logic [PL_W-1:0]    rpl_i,
  input  logic [1:0]         acc_i,
  input  logic [ADDR_W-1:0]  offset_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [ADDR_W-1:0]  lin_addr_o,
  output logic [2:0]         fault_o,
  output logic               op32_o
);
  logic              over;
  fault_e            fault_c;
  logic [ADDR_W-1:0] sum;
  logic [ADDR_W-1:0] lin_c;

  seg_lim_unit #(
    .ADDR_W     (ADDR_W),
    .LIMIT_W    (LIMIT_W),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_lim (
    .limit_i  (limit_i),
    .gran_i   (gran_i),
    .offset_i (offset_i),
    .over_o   (over)
  );

  seg_rights_unit #(
    .PL_W   (PL_W),
    .TYPE_W (TYPE_W)
  ) u_rights (
    .present_i (present_i),
    .seg_s_i   (seg_s_i),
    .type_i    (type_i),
    .dpl_i     (dpl_i),
    .cpl_i     (cpl_i),
    .rpl_i     (rpl_i),
    .acc_i     (acc_i),
    .over_i    (over),
    .fault_o   (fault_c)
  );

  assign sum   = base_i + offset_i;
  assign lin_c = (fault_c == FLT_NONE) ? sum : '0;

  seg_resp_reg #(
    .ADDR_W  (ADDR_W),
    .FAULT_W (3)
  ) u_resp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .lin_i       (lin_c),
    .fault_i     (fault_c),
    .op32_i      (dflt32_i),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .lin_o       (lin_addr_o),
    .fault_o     (fault_o),
    .op32_o      (op32_o)
  );
endmodule

// File: rtl/seg_addr_chk_sva.sv
module seg_addr_chk_sva (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        rsp_valid_o,
  input logic        rsp_ready_i,
  input logic [31:0] lin_addr_o,
  input logic [2:0]  fault_o,
  input logic        op32_o
);
  // R11
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(lin_addr_o)
      && $stable(fault_o) && $stable(op32_o));

  // R11
  stall_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |-> !req_ready_o);

  // R11
  accept_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  // R9
  fault_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> fault_o <= 3'd4);

  // R4
  fault_no_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && fault_o != 3'd0 |-> lin_addr_o == 32'd0);

  // R12
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_idle_chk: assert (!rsp_valid_o && req_ready_o);
    end
  end
endmodule

bind seg_addr_chk seg_addr_chk_sva u_sva (.*);

// File: tb/sim_seg_addr_chk.sv
module sim_seg_addr_chk;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] base_i = '0;
  logic [19:0] limit_i = '0;
  logic        gran_i = 1'b0;
  logic        present_i = 1'b0;
  logic        seg_s_i = 1'b0;
  logic [3:0]  type_i = '0;
  logic [1:0]  dpl_i = '0;
  logic        dflt32_i = 1'b0;
  logic [1:0]  cpl_i = '0;
  logic [1:0]  rpl_i = '0;
  logic [1:0]  acc_i = '0;
  logic [31:0] offset_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [31:0] lin_addr_o;
  logic [2:0]  fault_o;
  logic        op32_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] lin;
    logic [2:0]  flt;
    logic        op32;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  seg_addr_chk u0 (.*);

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 100000 && !done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // reference model built from the requirements
  function automatic exp_t model(input logic [31:0] b, input logic [19:0] l,
      input logic g, input logic p, input logic s, input logic [3:0] t,
      input logic [1:0] d, input logic [1:0] c, input logic [1:0] r,
      input logic [1:0] a, input logic [31:0] o, input logic op);
    exp_t e;
    logic [31:0] lim;
    logic [1:0] mx;
    logic bad_t;
    lim = g ? {l, 12'hFFF} : {12'd0, l};
    mx  = (c > r) ? c : r;
    case (a)
      2'd0: bad_t = t[3] & ~t[1];
      2'd1: bad_t = t[3] | ~t[1];
      2'd2: bad_t = ~t[3];
      default: bad_t = 1'b1;
    endcase
    if (!p) e.flt = 3'd1;
    else if (!s) e.flt = 3'd2;
    else if (mx > d || bad_t) e.flt = 3'd3;
    else if (o > lim) e.flt = 3'd4;
    else e.flt = 3'd0;
    e.lin  = (e.flt == 3'd0) ? b + o : 32'd0;
    e.op32 = op;
    return e;
  endfunction

  task automatic send(input string tag, input logic [31:0] b, input logic [19:0] l,
      input logic g, input logic p, input logic s, input logic [3:0] t,
      input logic [1:0] d, input logic [1:0] c, input logic [1:0] r,
      input logic [1:0] a, input logic [31:0] o, input logic op);
    exp_t e;
    e = model(b, l, g, p, s, t, d, c, r, a, o, op);
    e.tag = tag;
    exp_q.push_back(e);
    base_i = b; limit_i = l; gran_i = g; present_i = p; seg_s_i = s;
    type_i = t; dpl_i = d; cpl_i = c; rpl_i = r; acc_i = a; offset_i = o;
    dflt32_i = op;
    req_valid_i = 1'b1;
    #1;
    while (!req_ready_o) begin
      @(negedge clk_i);
      #1;
    end
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // monitor: compare each transferred response
  always @(negedge clk_i) begin
    if (rst_ni && rsp_valid_o && rsp_ready_i) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R11: unexpected response, actual fault %0d expected none", fault_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (fault_o !== e.flt || lin_addr_o !== e.lin) begin
          fails++;
          $display("FAIL %s: actual fault %0d lin %h, expected fault %0d lin %h",
                   e.tag, fault_o, lin_addr_o, e.flt, e.lin);
        end
        checks++;
        if (op32_o !== e.op32) begin
          fails++;
          $display("FAIL R10 (%s): actual op32 %0b expected %0b", e.tag, op32_o, e.op32);
        end
      end
    end
  end

  logic [31:0] held_lin;

  initial begin
    #12;
    checks++;
    if (rsp_valid_o !== 1'b0 || req_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R12: actual valid %0b ready %0b expected 0 1", rsp_valid_o, req_ready_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== 1'b0 || req_ready_o !== 1'b1) begin
      fails++;
      $display("FAIL R12: after reset actual valid %0b ready %0b expected 0 1",
               rsp_valid_o, req_ready_o);
    end

    // type 4'b0010 writable data, 4'b1010 readable code, 4'b1000 exec-only code
    send("R1", 32'h0010_0000, 20'hFFFFF, 1, 1, 1, 4'b0010, 2'd3, 2'd3, 2'd3, 2'd0, 32'h0000_1234, 1);
    send("R1", 32'hFFFF_F000, 20'hFFFFF, 1, 1, 1, 4'b0011, 2'd0, 2'd0, 2'd0, 2'd1, 32'h0000_2000, 0);
    send("R2", 32'h0000_4000, 20'h00100, 0, 1, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0100, 1);
    send("R2", 32'h0000_4000, 20'h00100, 0, 1, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0101, 1);
    send("R3", 32'h0000_0000, 20'h00002, 1, 1, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_2FFF, 0);
    send("R3", 32'h0000_0000, 20'h00002, 1, 1, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_3000, 0);
    send("R4", 32'h0000_8000, 20'hFFFFF, 1, 0, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0010, 1);
    send("R5", 32'h0000_8000, 20'hFFFFF, 1, 1, 0, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0010, 1);
    send("R6", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b0010, 2'd1, 2'd2, 2'd0, 2'd0, 32'h0000_0010, 1);
    send("R6", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b0010, 2'd1, 2'd0, 2'd3, 2'd0, 32'h0000_0010, 1);
    send("R6", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b0010, 2'd2, 2'd2, 2'd2, 2'd0, 32'h0000_0010, 1);
    send("R7", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b0000, 2'd3, 2'd0, 2'd0, 2'd1, 32'h0000_0010, 1);
    send("R7", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b1010, 2'd3, 2'd0, 2'd0, 2'd1, 32'h0000_0010, 1);
    send("R7", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b0110, 2'd3, 2'd0, 2'd0, 2'd1, 32'h0000_0010, 1);
    send("R8", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd2, 32'h0000_0010, 1);
    send("R8", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b1000, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0010, 1);
    send("R8", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b1100, 2'd3, 2'd0, 2'd0, 2'd2, 32'h0000_0010, 0);
    send("R8", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b1011, 2'd3, 2'd0, 2'd0, 2'd0, 32'h0000_0020, 1);
    send("R8", 32'h0000_8000, 20'hFFFFF, 1, 1, 1, 4'b1010, 2'd3, 2'd0, 2'd0, 2'd3, 32'h0000_0010, 1);
    send("R9", 32'h0000_8000, 20'h00001, 0, 0, 0, 4'b0000, 2'd0, 2'd3, 2'd3, 2'd1, 32'h0000_0100, 1);
    send("R9", 32'h0000_8000, 20'h00001, 0, 1, 0, 4'b0000, 2'd0, 2'd3, 2'd3, 2'd1, 32'h0000_0100, 1);
    send("R9", 32'h0000_8000, 20'h00001, 0, 1, 1, 4'b0000, 2'd0, 2'd3, 2'd3, 2'd1, 32'h0000_0100, 1);
    send("R9", 32'h0000_8000, 20'h00001, 0, 1, 1, 4'b0010, 2'd3, 2'd0, 2'd0, 2'd1, 32'h0000_0100, 0);

    // R11: stall the consumer and watch the held response
    @(negedge clk_i);
    rsp_ready_i = 1'b0;
    send("R11", 32'h1234_0000, 20'h0FFFF, 0, 1, 1, 4'b0010, 2'd3, 2'd1, 2'd1, 2'd0, 32'h0000_00AB, 1);
    held_lin = lin_addr_o;
    @(negedge clk_i);
    @(negedge clk_i);
    checks++;
    if (rsp_valid_o !== 1'b1 || req_ready_o !== 1'b0 || lin_addr_o !== held_lin
        || held_lin !== 32'h1234_00AB) begin
      fails++;
      $display("FAIL R11: stall actual valid %0b ready %0b lin %h expected 1 0 %h",
               rsp_valid_o, req_ready_o, lin_addr_o, 32'h1234_00AB);
    end
    rsp_ready_i = 1'b1;
    repeat (3) @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0 || rsp_valid_o !== 1'b0) begin
      fails++;
      $display("FAIL R11: pending actual %0d valid %0b expected 0 0", exp_q.size(), rsp_valid_o);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule